// File: doc/BRIEF.md
# Clock-Sampled Programmable Delay Line

This block delays a single-bit signal by a whole number of clock cycles chosen by a 3-bit step code. The delay is a fixed base latency plus one step increment for each unit of the code, so the eight settings are evenly spaced and strictly increasing. Both the base and the increment are parameters counted in cycles. Inside, a tapped shift register keeps the recent input history. A selector reads the tap that belongs to the present code, and a register drives the output.

The step code is used live and is never captured. A change on it moves the read point at the next clock edge and does not disturb the history. A separate blanking input forces the output low one cycle after it is sampled high. Blanking does not empty the history, so a pulse that entered before or during blanking can still emerge once blanking ends. Software or control logic that changes the code or uses blanking has to let the line drain first when stray pulses must be avoided.

Top module: `prog_delay_line`

## Requirements
- R1: With `step_sel` = a and `blank` held low, `out_sig` after clock edge n equals the `in_sig` value sampled at edge n − (TD0_CYC + a·TINC_CYC). Code a is the unsigned value of `step_sel`, from 0 to 7.
- R2: Each increase of `step_sel` by one adds exactly TINC_CYC cycles of delay, so delay rises strictly across all eight codes.
- R3: `step_sel` is not registered. After a code change, the output at the next edge is taken from the history at the new code's delay, and the history is unaffected.
- R4: The line holds at most TD0_CYC + 7·TINC_CYC samples. After that many consecutive low samples of `in_sig`, `out_sig` stays low for every code.
- R5: `blank` sampled high at an edge drives `out_sig` low after that edge, a one-cycle registered response. `out_sig` never rises at an edge that sampled `blank` high.
- R6: Synchronous active-low reset (`rst_n` low at an edge) clears every history stage and drives `out_sig` low. Values sampled during reset never reach the output.
- R7: Blanking does not flush the history. A pulse sampled before or during blanking appears at its normal delay if blanking has ended by then.
- R8: TD0_CYC and TINC_CYC must each be at least 1, and a value below 1 is rejected at elaboration. The longest delay (code 7) is TD0_CYC + 7·TINC_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_sig | input | 1 | Signal to be delayed |
| step_sel | input | ADDR_W (3) | Live delay step code |
| blank | input | 1 | Forces the output low while high (registered) |
| out_sig | output | 1 | Delayed signal |

## Verification
The embedded properties assume that every input is synchronous to `clk` and known at each sampling edge, and that reset is applied before the first checked cycle. The drain property also assumes that `in_sig` low means the line is idle. The bench changes `in_sig`, `step_sel`, `blank` and `rst_n` only on falling edges, so no input moves near a rising edge. It holds reset for several cycles at start-up before any check. Code changes and blanking are placed deliberately inside pulses in flight, so the live code and the retained history are exercised within those assumptions.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
   localparam int unsigned PDL_ADDR_W = 3;

   function automatic int unsigned pdl_depth(input int unsigned td0,
                                             input int unsigned tinc,
                                             input int unsigned addr_w);
      return td0 + (((1 << addr_w) - 1) * tinc);
   endfunction

   function automatic int unsigned pdl_tap_index(input int unsigned td0,
                                                 input int unsigned tinc,
                                                 input int unsigned code);
      return td0 + code * tinc - 1;
   endfunction
endpackage

// File: rtl/pdl_tap_line.sv
module pdl_tap_line #(
   parameter int unsigned DEPTH = 23
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   output logic [DEPTH-1:0] taps
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("pdl_tap_line: DEPTH must be at least 1");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_stage
         if (gi == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n) taps[0] <= 1'b0;
               else        taps[0] <= din;
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (!rst_n) taps[gi] <= 1'b0;
               else        taps[gi] <= taps[gi-1];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/pdl_tap_select.sv
module pdl_tap_select #(
   parameter int unsigned TD0_CYC    = 2,
   parameter int unsigned TINC_CYC   = 3,
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned DEPTH      = 23,
   parameter bit          SEL_ONEHOT = 1'b0
) (
   input  logic [DEPTH-1:0]  taps,
   input  logic [ADDR_W-1:0] code,
   output logic              sel
);
   import pdl_pkg::*;

   localparam int unsigned NSTEP = 1 << ADDR_W;

   generate
      if (pdl_depth(TD0_CYC, TINC_CYC, ADDR_W) != DEPTH) begin : g_bad_depth
         $error("pdl_tap_select: DEPTH does not match the step parameters");
      end
   endgenerate

   logic [NSTEP-1:0] cand;

   genvar ga;
   generate
      for (ga = 0; ga < NSTEP; ga++) begin : g_cand
         localparam int unsigned IDX = pdl_tap_index(TD0_CYC, TINC_CYC, ga);
         assign cand[ga] = taps[IDX];
      end
   endgenerate

   generate
      if (SEL_ONEHOT) begin : g_andor
         logic [NSTEP-1:0] hot;
         always_comb begin
            hot       = '0;
            hot[code] = 1'b1;
         end
         assign sel = |(cand & hot);
      end else begin : g_index
         assign sel = cand[code];
      end
   endgenerate
endmodule

// File: rtl/pdl_out_stage.sv
module pdl_out_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic blank,
   input  logic din,
   output logic out_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)     out_q <= 1'b0;
      else if (blank) out_q <= 1'b0;
      else            out_q <= din;
   end

   AST_RST_CLEARS_OUT: assert property (@(posedge clk)
      !rst_n |=> !out_q);                                              // R6

   AST_BLANK_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      blank |=> !out_q);                                               // R5
endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line #(
   parameter int unsigned TD0_CYC    = 2,
   parameter int unsigned TINC_CYC   = 3,
   parameter int unsigned ADDR_W     = pdl_pkg::PDL_ADDR_W,
   parameter bit          SEL_ONEHOT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_sig,
   input  logic [ADDR_W-1:0] step_sel,
   input  logic              blank,
   output logic              out_sig
);
   import pdl_pkg::*;

   localparam int unsigned DEPTH = pdl_depth(TD0_CYC, TINC_CYC, ADDR_W);
   localparam int unsigned QW    = $clog2(DEPTH + 1);

   // R8: parameter legality at elaboration
   generate
      if (TD0_CYC < 1) begin : g_bad_td0
         $error("prog_delay_line: TD0_CYC must be at least 1");
      end
      if (TINC_CYC < 1) begin : g_bad_tinc
         $error("prog_delay_line: TINC_CYC must be at least 1");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("prog_delay_line: ADDR_W must be at least 1");
      end
   endgenerate

   logic [DEPTH-1:0] taps;
   logic             picked;

   pdl_tap_line #(.DEPTH(DEPTH)) u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (in_sig),
      .taps  (taps)
   );

   pdl_tap_select #(
      .TD0_CYC    (TD0_CYC),
      .TINC_CYC   (TINC_CYC),
      .ADDR_W     (ADDR_W),
      .DEPTH      (DEPTH),
      .SEL_ONEHOT (SEL_ONEHOT)
   ) u_sel (
      .taps (taps),
      .code (step_sel),
      .sel  (picked)
   );

   pdl_out_stage u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .blank (blank),
      .din   (picked),
      .out_q (out_sig)
   );

   // Run of consecutive low input samples, saturating at the line depth.
   logic [QW-1:0] quiet_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)                      quiet_cnt <= '0;
      else if (in_sig)                 quiet_cnt <= '0;
      else if (quiet_cnt != QW'(DEPTH)) quiet_cnt <= quiet_cnt + 1'b1;
   end

   AST_DRAINED_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_cnt == QW'(DEPTH)) |=> !out_sig);                         // R4

   AST_NO_RISE_WHILE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_sig) |-> !$past(blank));                               // R5
endmodule

// File: tb/prog_delay_line_test.sv
`timescale 1ns/1ps
module prog_delay_line_test;
   localparam int TD0   = 2;
   localparam int TINC  = 3;
   localparam int DEPTH = TD0 + 7 * TINC;
   localparam int NVEC  = 32;

   // vector format {blank, step_sel[2:0], in_sig}
   localparam logic [4:0] VEC [NVEC] = '{
      5'b0_000_1, 5'b0_000_0, 5'b0_000_1, 5'b0_000_1,
      5'b0_000_0, 5'b0_001_1, 5'b0_001_0, 5'b0_001_0,
      5'b0_001_1, 5'b0_001_1, 5'b0_001_1, 5'b0_010_0,
      5'b0_010_1, 5'b0_010_0, 5'b1_010_1, 5'b1_010_1,
      5'b0_010_0, 5'b0_011_1, 5'b0_011_0, 5'b0_111_1,
      5'b0_111_0, 5'b0_000_1, 5'b0_100_0, 5'b0_100_1,
      5'b1_100_1, 5'b0_101_0, 5'b0_110_1, 5'b0_110_1,
      5'b0_011_0, 5'b0_001_0, 5'b0_000_1, 5'b0_000_0
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_sig = 1'b0;
   logic [2:0] step_sel = 3'd0;
   logic       blank = 1'b0;
   logic       out_sig;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   prog_delay_line #(.TD0_CYC(TD0), .TINC_CYC(TINC)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_sig   (in_sig),
      .step_sel (step_sel),
      .blank    (blank),
      .out_sig  (out_sig)
   );

   // Reference model: input history plus the delay formula.
   logic [63:0] hist = '0;
   logic        exp_q = 1'b0;
   always @(posedge clk) begin
      int d;
      d = TD0 + int'(step_sel) * TINC;
      if (!rst_n) begin
         hist  <= '0;
         exp_q <= 1'b0;
      end else begin
         hist  <= {hist[62:0], in_sig};
         exp_q <= blank ? 1'b0 : hist[d-1];
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog: got %0d cycles expected fewer than 100000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input logic act, input logic exp, input string tag, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
      end
   endtask

   task automatic chk_int(input int act, input int exp, input string tag, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic drain(input logic [2:0] code);
      @(negedge clk);
      in_sig = 1'b0; blank = 1'b0; step_sel = code;
      repeat (DEPTH + 2) @(negedge clk);
   endtask

   // Single-cycle pulse; returns edges from sampling edge to output high.
   task automatic measure(input logic [2:0] code, output int lat);
      int edges;
      drain(code);
      in_sig = 1'b1;
      @(negedge clk);
      in_sig = 1'b0;
      edges = 1;
      while (out_sig !== 1'b1 && edges < 60) begin
         @(negedge clk);
         edges++;
      end
      lat = edges - 1;
   endtask

   initial begin
      int lat [8];
      int edges;
      string tag;

      // R6: reset state, with in_sig high throughout reset
      in_sig = 1'b1;
      repeat (4) @(negedge clk);
      chk(out_sig, 1'b0, "R6", "output during reset");
      rst_n = 1'b1; in_sig = 1'b0;
      repeat (3) begin
         @(negedge clk);
         chk(out_sig, 1'b0, "R6", "samples taken in reset must not emerge");
      end

      // Vector table against the reference model
      for (int i = 0; i < NVEC; i++) begin
         logic [2:0] prev;
         prev = step_sel;
         blank = VEC[i][4]; step_sel = VEC[i][3:1]; in_sig = VEC[i][0];
         tag = VEC[i][4] ? "R5" : (VEC[i][3:1] != prev ? "R3" : "R1");
         @(negedge clk);
         chk(out_sig, exp_q, tag, $sformatf("table vector %0d", i));
      end

      // R1, R2, R8: latency per code
      for (int a = 0; a < 8; a++) begin
         measure(3'(a), lat[a]);
         chk_int(lat[a], TD0 + a * TINC, "R1", $sformatf("latency at code %0d", a));
      end
      for (int a = 1; a < 8; a++)
         chk_int(lat[a] - lat[a-1], TINC, "R2", $sformatf("step between codes %0d and %0d", a - 1, a));
      chk_int(lat[7], DEPTH, "R8", "longest delay equals line depth");

      // R5: registered blanking response
      @(negedge clk);
      step_sel = 3'd0; in_sig = 1'b1;
      repeat (6) @(negedge clk);
      chk(out_sig, 1'b1, "R1", "steady high passes");
      blank = 1'b1;
      chk(out_sig, 1'b1, "R5", "output before blank is sampled");
      @(negedge clk);
      chk(out_sig, 1'b0, "R5", "output one edge after blank");
      blank = 1'b0;
      @(negedge clk);
      chk(out_sig, 1'b1, "R5", "output after blank released");

      // R7: pulse survives blanking
      drain(3'd7);
      in_sig = 1'b1;
      @(negedge clk);
      in_sig = 1'b0; blank = 1'b1;
      edges = 1;
      repeat (5) begin
         @(negedge clk);
         edges++;
         chk(out_sig, 1'b0, "R5", "output held low while blanked");
      end
      blank = 1'b0;
      while (out_sig !== 1'b1 && edges < 60) begin
         @(negedge clk);
         edges++;
      end
      chk_int(edges - 1, DEPTH, "R7", "pulse emerges after blanking");
      @(negedge clk);
      chk(out_sig, 1'b0, "R7", "pulse width kept at one cycle");

      // R3: live code change while a pulse is in flight
      drain(3'd7);
      in_sig = 1'b1;
      @(negedge clk);
      in_sig = 1'b0;
      repeat (3) @(negedge clk);
      step_sel = 3'd1;
      @(negedge clk);
      chk(out_sig, 1'b0, "R3", "before new delay reached");
      @(negedge clk);
      chk(out_sig, 1'b1, "R3", "pulse at new delay");

      // R6: reset mid-stream clears history
      @(negedge clk);
      step_sel = 3'd0; in_sig = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(out_sig, 1'b0, "R6", "reset drives output low");
      rst_n = 1'b1; in_sig = 1'b0; step_sel = 3'd7;
      @(negedge clk);
      step_sel = 3'd0;
      repeat (2) begin
         @(negedge clk);
         chk(out_sig, 1'b0, "R6", "history cleared by reset");
      end

      // R4: drained line is quiet at every code
      @(negedge clk);
      in_sig = 1'b1;
      repeat (3) @(negedge clk);
      in_sig = 1'b0;
      repeat (DEPTH) @(negedge clk);
      for (int a = 0; a < 8; a++) begin
         step_sel = 3'(a);
         @(negedge clk);
         chk(out_sig, 1'b0, "R4", $sformatf("drained line at code %0d", a));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule